// File: doc/BRIEF.md
# Probe Trigger Comparator

This block watches one debug probe word and raises a one-bit hit flag on every clock in which the probe meets a programmed condition. The hit is registered and feeds a trigger or capture combiner further along the debug path. Two compare styles exist. Word mode compares the whole probe against a programmed value with one of six magnitude operators, in either unsigned or two's-complement signed arithmetic. Pattern mode gives every probe bit its own 3-bit code: a level (0 or 1), don't-care, or a change test (rising, falling, either edge, no transition) against the probe value held from the previous clock.

Configuration is loaded through a small register port: a write strobe, a 2-bit register select and a data word. Configuration registers are not cleared by reset, so a condition can be loaded while reset is still held and is then in force from the first active clock. Only the edge history and the hit flag are reset.

Register select 0 is control: bit 0 picks pattern mode (1) or word mode (0), bits 3:1 hold the word operator, and bit 4 selects signed arithmetic. Select 1 holds the compare value in its low WIDTH bits. Select 2 holds the bit codes, with the code for probe bit i in data bits 3i+2 to 3i. Select 3 is ignored.

Top module: `ptc_trig_cmp`

## Requirements
- R1: While rst is high the hit output is 0, and it stays 0 until the first rising clock edge after rst falls; configuration written before or during reset is kept through reset.
- R2: In word mode the operator field selects probe OP value with 0 = equal, 1 = not equal, 2 = less than, 3 = less or equal, 4 = greater than, 5 = greater or equal; operator codes 6 and 7 never produce a hit.
- R3: With control bit 4 set, word-mode magnitude operators treat probe and value as two's-complement signed numbers; with it clear, as unsigned.
- R4: In word mode every bit whose code is 010 (don't-care) is forced to 0 in both probe and value before comparing; other codes have no effect in word mode.
- R5: In pattern mode the hit requires every bit to match its code; code 000 matches a 0, 001 matches a 1, 010 always matches.
- R6: Edge codes compare the current probe bit with the bit from the previous clock: 011 matches a 0-to-1 change, 100 a 1-to-0 change, 101 any change, 110 no change.
- R7: At the first clock edge after reset is released no edge code (011, 100, 101, 110) matches.
- R8: Bit code 111 is reserved and never matches, so a pattern containing it never hits.
- R9: The hit reflects the probe and configuration present one clock earlier; a configuration write is used from the clock after it is written, and a write does not clear the edge history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears hit and edge history |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 value, 2 bit codes, 3 ignored |
| cfg_wdata | input | 3*WIDTH | Configuration data |
| probe | input | WIDTH | Probe word sampled every clock |
| hit | output | 1 | Registered match flag |

## Verification
The bench builds the block with WIDTH set to 8, so the signed boundaries 0x7F, 0x80 and 0xFF sit in small literals and the full bit-code vector fits a 24-bit word that the bench assembles lane by lane. With that width the sign bit itself can be masked as don't-care, which exposes the case where signed and unsigned results differ only through masking. Edge codes are exercised across reset release and across configuration writes, which reaches the history-valid corner and the rule that a write keeps the history.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  localparam logic [2:0] OP_EQ  = 3'd0;
  localparam logic [2:0] OP_NE  = 3'd1;
  localparam logic [2:0] OP_LT  = 3'd2;
  localparam logic [2:0] OP_LE  = 3'd3;
  localparam logic [2:0] OP_GT  = 3'd4;
  localparam logic [2:0] OP_GE  = 3'd5;

  localparam logic [2:0] BC_ZERO = 3'b000;
  localparam logic [2:0] BC_ONE  = 3'b001;
  localparam logic [2:0] BC_DC   = 3'b010;
  localparam logic [2:0] BC_RISE = 3'b011;
  localparam logic [2:0] BC_FALL = 3'b100;
  localparam logic [2:0] BC_ANY  = 3'b101;
  localparam logic [2:0] BC_HOLD = 3'b110;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_VALUE = 2'd1;
  localparam logic [1:0] SEL_CODES = 2'd2;

  // Match of one probe lane against its code.
  function automatic logic lane_match(input logic [2:0] code, input logic cur,
                                      input logic prv, input logic hv);
    logic m;
    case (code)
      BC_ZERO: m = ~cur;
      BC_ONE:  m = cur;
      BC_DC:   m = 1'b1;
      BC_RISE: m = hv & cur & ~prv;
      BC_FALL: m = hv & ~cur & prv;
      BC_ANY:  m = hv & (cur ^ prv);
      BC_HOLD: m = hv & ~(cur ^ prv);
      default: m = 1'b0;
    endcase
    return m;
  endfunction

  function automatic logic is_edge_code(input logic [2:0] code);
    return (code == BC_RISE) || (code == BC_FALL) ||
           (code == BC_ANY) || (code == BC_HOLD);
  endfunction

  // Operator applied to precomputed equal / less-than flags.
  function automatic logic apply_op(input logic [2:0] op, input logic eq,
                                    input logic lt);
    logic r;
    case (op)
      OP_EQ:   r = eq;
      OP_NE:   r = ~eq;
      OP_LT:   r = lt;
      OP_LE:   r = lt | eq;
      OP_GT:   r = ~lt & ~eq;
      OP_GE:   r = ~lt;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ptc_cfg_regs.sv
module ptc_cfg_regs #(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_addr,
  input  logic [3*WIDTH-1:0]   cfg_wdata,
  output logic                 pat_mode,
  output logic [2:0]           op_sel,
  output logic                 sgn_mode,
  output logic [WIDTH-1:0]     cmp_value,
  output logic [3*WIDTH-1:0]   bit_codes
);
  import ptc_pkg::*;

  // Configuration is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (cfg_wr) begin
      case (cfg_addr)
        SEL_CTRL: begin
          pat_mode <= cfg_wdata[0];
          op_sel   <= cfg_wdata[3:1];
          sgn_mode <= cfg_wdata[4];
        end
        SEL_VALUE: cmp_value <= cfg_wdata[WIDTH-1:0];
        SEL_CODES: bit_codes <= cfg_wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ptc_history.sv
module ptc_history #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] probe,
  output logic [WIDTH-1:0] prev_probe,
  output logic             hist_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_probe <= '0;
      hist_valid <= 1'b0;
    end else begin
      prev_probe <= probe;
      hist_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/ptc_pattern_match.sv
module ptc_pattern_match #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   probe,
  input  logic [WIDTH-1:0]   prev_probe,
  input  logic               hist_valid,
  input  logic [3*WIDTH-1:0] bit_codes,
  output logic               pat_match,
  output logic [WIDTH-1:0]   dc_mask,
  output logic               edge_code_any,
  output logic               rsvd_code_any,
  output logic               all_dc
);
  import ptc_pkg::*;

  logic [WIDTH-1:0] lane_ok;
  logic [WIDTH-1:0] lane_edge;
  logic [WIDTH-1:0] lane_rsvd;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic [2:0] code;
    assign code         = bit_codes[3*i +: 3];
    assign lane_ok[i]   = lane_match(code, probe[i], prev_probe[i], hist_valid);
    assign dc_mask[i]   = (code == BC_DC);
    assign lane_edge[i] = is_edge_code(code);
    assign lane_rsvd[i] = (code == 3'b111);
  end

  assign pat_match     = &lane_ok;
  assign edge_code_any = |lane_edge;
  assign rsvd_code_any = |lane_rsvd;
  assign all_dc        = &dc_mask;

endmodule

// File: rtl/ptc_word_cmp.sv
module ptc_word_cmp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] probe,
  input  logic [WIDTH-1:0] cmp_value,
  input  logic [WIDTH-1:0] dc_mask,
  input  logic [2:0]       op_sel,
  input  logic             sgn_mode,
  output logic             word_match
);
  import ptc_pkg::*;

  localparam logic [WIDTH-1:0] SIGN_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] a_m, b_m, flip, a_k, b_k;
  logic             eq, lt;

  // Signed order equals unsigned order once the sign bit is inverted.
  assign a_m  = probe & ~dc_mask;
  assign b_m  = cmp_value & ~dc_mask;
  assign flip = sgn_mode ? SIGN_BIT : '0;
  assign a_k  = a_m ^ flip;
  assign b_k  = b_m ^ flip;
  assign eq   = (a_m == b_m);
  assign lt   = (a_k < b_k);

  assign word_match = apply_op(op_sel, eq, lt);

endmodule

// File: rtl/ptc_trig_cmp.sv
module ptc_trig_cmp #(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_addr,
  input  logic [3*WIDTH-1:0]   cfg_wdata,
  input  logic [WIDTH-1:0]     probe,
  output logic                 hit
);

  logic                 pat_mode;
  logic [2:0]           op_sel;
  logic                 sgn_mode;
  logic [WIDTH-1:0]     cmp_value;
  logic [3*WIDTH-1:0]   bit_codes;
  logic [WIDTH-1:0]     prev_probe;
  logic                 hist_valid;
  logic                 pat_match;
  logic [WIDTH-1:0]     dc_mask;
  logic                 edge_code_any;
  logic                 rsvd_code_any;
  logic                 all_dc;
  logic                 word_match;
  logic                 hit_next;

  ptc_cfg_regs #(.WIDTH(WIDTH)) cfg_i (
    .clk       (clk),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pat_mode  (pat_mode),
    .op_sel    (op_sel),
    .sgn_mode  (sgn_mode),
    .cmp_value (cmp_value),
    .bit_codes (bit_codes)
  );

  ptc_history #(.WIDTH(WIDTH)) hist_i (
    .clk        (clk),
    .rst        (rst),
    .probe      (probe),
    .prev_probe (prev_probe),
    .hist_valid (hist_valid)
  );

  ptc_pattern_match #(.WIDTH(WIDTH)) pat_i (
    .probe         (probe),
    .prev_probe    (prev_probe),
    .hist_valid    (hist_valid),
    .bit_codes     (bit_codes),
    .pat_match     (pat_match),
    .dc_mask       (dc_mask),
    .edge_code_any (edge_code_any),
    .rsvd_code_any (rsvd_code_any),
    .all_dc        (all_dc)
  );

  ptc_word_cmp #(.WIDTH(WIDTH)) word_i (
    .probe      (probe),
    .cmp_value  (cmp_value),
    .dc_mask    (dc_mask),
    .op_sel     (op_sel),
    .sgn_mode   (sgn_mode),
    .word_match (word_match)
  );

  assign hit_next = pat_mode ? pat_match : word_match;

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= hit_next;
  end

endmodule

// File: rtl/ptc_trig_cmp_chk.sv
module ptc_trig_cmp_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             hit,
  input logic             cfg_wr,
  input logic             pat_mode,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] cmp_value,
  input logic             hist_valid,
  input logic             edge_code_any,
  input logic             rsvd_code_any,
  input logic             all_dc
);

  AST_OFF_NEVER_HITS: assert property (@(posedge clk) disable iff (rst)
    (!pat_mode && op_sel >= 3'd6) |=> !hit); // R2

  AST_ALL_DONTCARE_HITS: assert property (@(posedge clk) disable iff (rst)
    (pat_mode && all_dc) |=> hit); // R5

  AST_EDGE_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
    (pat_mode && !hist_valid && edge_code_any) |=> !hit); // R7

  AST_RESERVED_CODE_MISSES: assert property (@(posedge clk) disable iff (rst)
    (pat_mode && rsvd_code_any) |=> !hit); // R8

  AST_VALUE_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cmp_value)); // R9

endmodule

bind ptc_trig_cmp ptc_trig_cmp_chk #(.WIDTH(WIDTH)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .hit           (hit),
  .cfg_wr        (cfg_wr),
  .pat_mode      (pat_mode),
  .op_sel        (op_sel),
  .cmp_value     (cmp_value),
  .hist_valid    (hist_valid),
  .edge_code_any (edge_code_any),
  .rsvd_code_any (rsvd_code_any),
  .all_dc        (all_dc)
);

// File: tb/ptc_trig_cmp_tb_top.sv
module ptc_trig_cmp_tb_top;

  localparam int W  = 8;
  localparam int CW = 3 * W;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_wr;
  logic [1:0]    cfg_addr;
  logic [CW-1:0] cfg_wdata;
  logic [W-1:0]  probe;
  logic          hit;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ptc_trig_cmp #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .probe(probe), .hit(hit)
  );

  // {op[2:0], signed, value[7:0], probe[7:0], expected}
  localparam logic [20:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'h5A, 8'h5A, 1'b1},
    {3'd0, 1'b0, 8'h5A, 8'h5B, 1'b0},
    {3'd1, 1'b0, 8'h5A, 8'h5B, 1'b1},
    {3'd2, 1'b0, 8'h80, 8'h7F, 1'b1},
    {3'd2, 1'b1, 8'h80, 8'h7F, 1'b0},
    {3'd3, 1'b0, 8'h10, 8'h10, 1'b1},
    {3'd4, 1'b1, 8'hFF, 8'h00, 1'b1},
    {3'd4, 1'b0, 8'hFF, 8'h00, 1'b0},
    {3'd5, 1'b1, 8'h05, 8'hFB, 1'b0},
    {3'd5, 1'b0, 8'h05, 8'hFB, 1'b1},
    {3'd6, 1'b0, 8'h00, 8'h00, 1'b0},
    {3'd3, 1'b1, 8'h81, 8'h80, 1'b1}
  };

  function automatic logic [CW-1:0] codes(input logic [2:0] lane0,
                                          input logic [2:0] others);
    logic [CW-1:0] c;
    for (int i = 0; i < W; i++) c[3*i +: 3] = (i == 0) ? lane0 : others;
    return c;
  endfunction

  function automatic logic [CW-1:0] ctrl(input logic pat, input logic [2:0] op,
                                         input logic sgn);
    logic [CW-1:0] c;
    c = '0;
    c[0] = pat;
    c[3:1] = op;
    c[4] = sgn;
    return c;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    cfg_wr = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic step(input logic [W-1:0] p);
    probe = p;
    tick();
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s hit=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; probe = '0;
    #1;
    // R1: configuration loaded while reset is held
    wr(2'd0, ctrl(1'b0, 3'd7, 1'b0));
    wr(2'd2, '0);
    wr(2'd1, '0);
    check("R1 reset", hit, 1'b0);
    rst = 1'b0;
    step(8'h00);
    check("R1 after release, op off kept", hit, 1'b0);

    // R2 R3: operator table
    for (int k = 0; k < NV; k++) begin
      wr(2'd0, ctrl(1'b0, VEC[k][20:18], VEC[k][17]));
      wr(2'd1, CW'(VEC[k][16:9]));
      step(VEC[k][8:1]);
      check($sformatf("R2/R3 vector %0d", k), hit, VEC[k][0]);
    end

    // R4: low nibble don't-care in word mode
    wr(2'd2, codes(3'b010, 3'b000) | CW'(24'h000490));
    wr(2'd0, ctrl(1'b0, 3'd0, 1'b0));
    wr(2'd1, CW'(8'hA0));
    step(8'hA7);
    check("R4 masked nibble equal", hit, 1'b1);
    step(8'hB7);
    check("R4 unmasked bit differs", hit, 1'b0);
    // R4 R3: masked sign bit in signed mode
    wr(2'd2, CW'(24'h400000));
    wr(2'd0, ctrl(1'b0, 3'd4, 1'b1));
    wr(2'd1, CW'(8'h01));
    step(8'h85);
    check("R4 signed with sign bit masked", hit, 1'b1);

    // R5: static pattern, bit0=1, bit1=0, rest X
    wr(2'd2, codes(3'b001, 3'b010) & ~CW'(24'h000038));
    wr(2'd0, ctrl(1'b1, 3'd0, 1'b0));
    step(8'hF1);
    check("R5 pattern match", hit, 1'b1);
    step(8'hF3);
    check("R5 pattern miss", hit, 1'b0);
    wr(2'd2, codes(3'b010, 3'b010));
    step(8'h3C);
    check("R5 all don't-care", hit, 1'b1);

    // R7 R6: rising edge across reset release
    rst = 1'b1;
    wr(2'd2, codes(3'b011, 3'b010));
    probe = 8'h01;
    rst = 1'b0;
    tick();
    check("R7 no edge on first clock", hit, 1'b0);
    step(8'h00);
    check("R6 rise code on fall", hit, 1'b0);
    step(8'h01);
    check("R6 rising edge", hit, 1'b1);
    step(8'h01);
    check("R6 rise code held high", hit, 1'b0);

    // R9 R6: write keeps history, falling edge
    wr(2'd2, codes(3'b100, 3'b010));
    step(8'h00);
    check("R9 history kept over write, falling", hit, 1'b1);
    // R6: either edge
    wr(2'd2, codes(3'b101, 3'b010));
    step(8'h01);
    check("R6 either edge", hit, 1'b1);
    step(8'h01);
    check("R6 either edge no change", hit, 1'b0);
    // R6: no transition
    wr(2'd2, codes(3'b110, 3'b010));
    step(8'h01);
    check("R6 no transition", hit, 1'b1);
    step(8'h00);
    check("R6 no transition broken", hit, 1'b0);

    // R8: reserved code
    wr(2'd2, codes(3'b111, 3'b010));
    step(8'h00);
    check("R8 reserved code low", hit, 1'b0);
    step(8'h01);
    check("R8 reserved code high", hit, 1'b0);

    // R9: configuration used from the next clock
    wr(2'd2, '0);
    wr(2'd0, ctrl(1'b0, 3'd0, 1'b0));
    wr(2'd1, CW'(8'h10));
    probe = 8'h33;
    wr(2'd1, CW'(8'h33));
    check("R9 old value on write clock", hit, 1'b0);
    step(8'h33);
    check("R9 new value next clock", hit, 1'b1);

    // R1: reset clears hit, configuration survives
    rst = 1'b1;
    tick();
    check("R1 reset clears hit", hit, 1'b0);
    rst = 1'b0;
    step(8'h33);
    check("R1 configuration survives reset", hit, 1'b1);

    finish_run();
  end

endmodule